// File: doc/BRIEF.md
# Receive Endpoint Packet Combiner

The combiner sits between a USB packet receiver and the FIFO of a receive endpoint. The receiver reports each packet it has finished taking in, together with that packet's byte count. The combiner keeps a running total of bytes and packets and decides where one software-visible block ends and the next one starts. When a block closes, the combiner raises a ready flag and presents the block's byte count, its packet count and an incomplete flag. It holds these values until software acknowledges the block.

There are two ways of working. In bulk mode, with merging enabled, packets are added up until one of two things happens: a short packet arrives, or the number of packets reaches the configured multiplier. With merging disabled, every packet is a block of its own. In high-bandwidth isochronous mode, every packet received within one microframe goes into one block, which closes at the next start-of-microframe strobe. The block is flagged incomplete when fewer packets arrived than the configured count per microframe.

Top module: `rxc_combiner`

## Requirements
- R1: In bulk mode with `cfg_merge` low, every accepted packet closes a block of its own, with `blk_pkts` = 1 and `blk_bytes` equal to that packet's length.
- R2: In bulk mode with `cfg_merge` high, an accepted packet whose length is below the payload size closes the block, and that packet is included in it. A zero-length packet counts as short.
- R3: In bulk mode with `cfg_merge` high, the block closes on the packet that brings the packet count up to the multiplier. A `cfg_mult` of 0 acts as 1, values above 32 act as 32, and 32 packets is the largest block.
- R4: The payload size comes from `cfg_size`: 0→8, 1→16, 2→32 and 3→64 bytes. Code 4 gives 512 bytes when `cfg_hs` is 1 and 64 bytes when it is 0. Codes 5 to 7 give 64 bytes.
- R5: In isochronous mode (`cfg_iso`=1), packets are summed until `uframe_sof`, which closes the block. A packet reported in the same cycle as the strobe belongs to the closing block. A strobe that arrives with no packets gathered produces no block.
- R6: In isochronous mode, the packets per microframe come from `cfg_iso_pkts` (1 to 3, with 0 acting as 1). Packets beyond that count within a microframe are discarded.
- R7: `blk_short` is 1 only for an isochronous block that holds fewer packets than configured. It is always 0 for bulk blocks.
- R8: `blk_ready` rises in the cycle after the closing event. `blk_bytes`, `blk_pkts` and `blk_short` stay unchanged while `blk_ready` is high and `blk_ack` is low. An `blk_ack` sampled while ready clears `blk_ready` on the next cycle.
- R9: While `blk_ready` is high, incoming packets and microframe strobes are ignored. They add nothing to the reported block or to the next one.
- R10: After reset, `blk_ready`, `blk_bytes`, `blk_pkts` and `blk_short` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_iso | input | 1 | 1 selects high-bandwidth isochronous combining, 0 selects bulk |
| cfg_merge | input | 1 | Bulk merging enable |
| cfg_hs | input | 1 | High-speed link, which allows the 512-byte payload |
| cfg_size | input | 3 | Bulk payload size code (see R4) |
| cfg_mult | input | 6 | Bulk packet multiplier |
| cfg_iso_pkts | input | 2 | Expected isochronous packets per microframe |
| rx_done | input | 1 | One-cycle strobe: a packet has been received |
| rx_len | input | LEN_W (11) | Byte count of the packet reported by `rx_done` |
| uframe_sof | input | 1 | One-cycle start-of-microframe strobe |
| blk_ack | input | 1 | Software acknowledges the pending block |
| blk_ready | output | 1 | A closed block is waiting |
| blk_bytes | output | LEN_W+5 (16) | Total bytes in the pending block |
| blk_pkts | output | 6 | Packets in the pending block |
| blk_short | output | 1 | Isochronous block with fewer packets than configured |

## Verification
The bench aims at the ways a block can end. These are the multiplier being reached, including at 1, 0 and 32, a short or zero-length packet, and the microframe strobe, including a strobe that arrives in the same cycle as a packet. A combiner that is off by one on the multiplier closes one packet early or one packet late. A combiner that gets the short-packet comparison wrong either merges across a short packet or splits on a full one. Packets sent while a block is pending must not change the held counts. A design that dropped them badly would corrupt the reported block, or it would leak bytes into the next block, or it would raise a second block after an empty strobe. The 512-byte code is also tried with the high-speed input low, where a design that ignores that input closes on the first 100-byte packet.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int PSZ_W      = 10;  // enough for 512
  localparam int CNT_W      = 6;   // packet counter, holds up to 32
  localparam int MULT_LIMIT = 32;
  localparam int ISO_W      = 2;

  // Payload size in bytes for a size code; 512 only on a high-speed link.
  function automatic logic [PSZ_W-1:0] payload_bytes(input logic [2:0] code,
                                                      input logic hs);
    case (code)
      3'd0:    return 10'd8;
      3'd1:    return 10'd16;
      3'd2:    return 10'd32;
      3'd3:    return 10'd64;
      3'd4:    return hs ? 10'd512 : 10'd64;
      default: return 10'd64;
    endcase
  endfunction

  // Multiplier clamped into 1..MULT_LIMIT.
  function automatic logic [CNT_W-1:0] eff_mult(input logic [CNT_W-1:0] m);
    if (m == '0) return CNT_W'(1);
    if (m > CNT_W'(MULT_LIMIT)) return CNT_W'(MULT_LIMIT);
    return m;
  endfunction

  // Isochronous packets per microframe, 0 read as 1.
  function automatic logic [ISO_W-1:0] eff_iso_cap(input logic [ISO_W-1:0] c);
    return (c == '0) ? ISO_W'(1) : c;
  endfunction
endpackage

// File: rtl/rxc_boundary.sv
module rxc_boundary
  import rxc_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int BYTES_W = 16
) (
  input  logic               cfg_iso,
  input  logic               cfg_merge,
  input  logic               cfg_hs,
  input  logic [2:0]         cfg_size,
  input  logic [CNT_W-1:0]   cfg_mult,
  input  logic [ISO_W-1:0]   cfg_iso_pkts,
  input  logic               rx_done,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic               uframe_sof,
  input  logic               busy,
  input  logic [BYTES_W-1:0] acc_bytes,
  input  logic [CNT_W-1:0]   acc_cnt,
  output logic               take,
  output logic               close,
  output logic [BYTES_W-1:0] close_bytes,
  output logic [CNT_W-1:0]   close_cnt,
  output logic               close_short
);
  logic [PSZ_W-1:0]   psize;
  logic [CNT_W-1:0]   mult_lim;
  logic [CNT_W-1:0]   iso_lim;
  logic [BYTES_W-1:0] sum;
  logic [CNT_W-1:0]   n_next;
  logic               is_short;
  logic               iso_room;
  logic               bulk_close;
  logic               iso_close;

  always_comb begin
    psize    = payload_bytes(cfg_size, cfg_hs);
    mult_lim = eff_mult(cfg_mult);
    iso_lim  = CNT_W'(eff_iso_cap(cfg_iso_pkts));
    sum      = acc_bytes + BYTES_W'(rx_len);
    n_next   = acc_cnt + CNT_W'(1);
    is_short = rx_len < LEN_W'(psize);
    iso_room = acc_cnt < iso_lim;

    take       = rx_done && !busy && (!cfg_iso || iso_room);
    bulk_close = !cfg_iso && take &&
                 (!cfg_merge || is_short || (n_next >= mult_lim));
    iso_close  = cfg_iso && uframe_sof && !busy && ((acc_cnt != '0) || take);
    close      = bulk_close || iso_close;

    close_bytes = take ? sum    : acc_bytes;
    close_cnt   = take ? n_next : acc_cnt;
    close_short = cfg_iso && (close_cnt < iso_lim);
  end
endmodule

// File: rtl/rxc_accum.sv
module rxc_accum
  import rxc_pkg::*;
#(
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               take,
  input  logic               close,
  input  logic [BYTES_W-1:0] upd_bytes,
  input  logic [CNT_W-1:0]   upd_cnt,
  output logic [BYTES_W-1:0] acc_bytes,
  output logic [CNT_W-1:0]   acc_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_bytes <= '0;
      acc_cnt   <= '0;
    end else if (close) begin
      acc_bytes <= '0;
      acc_cnt   <= '0;
    end else if (take) begin
      acc_bytes <= upd_bytes;
      acc_cnt   <= upd_cnt;
    end
  end

  // R9
  acc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(acc_bytes) && $stable(acc_cnt)));

  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cnt <= CNT_W'(MULT_LIMIT));
endmodule

// File: rtl/rxc_report.sv
module rxc_report
  import rxc_pkg::*;
#(
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               close,
  input  logic [BYTES_W-1:0] close_bytes,
  input  logic [CNT_W-1:0]   close_cnt,
  input  logic               close_short,
  input  logic               ack,
  output logic               ready,
  output logic [BYTES_W-1:0] bytes,
  output logic [CNT_W-1:0]   pkts,
  output logic               short_blk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      bytes     <= '0;
      pkts      <= '0;
      short_blk <= 1'b0;
    end else if (close) begin
      ready     <= 1'b1;
      bytes     <= close_bytes;
      pkts      <= close_cnt;
      short_blk <= close_short;
    end else if (ready && ack) begin
      ready <= 1'b0;
    end
  end

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ack) |=> (ready && $stable(bytes) && $stable(pkts) && $stable(short_blk)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ack) |=> !ready);

  // R8
  close_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (ready && pkts == $past(close_cnt)));

  // R9
  no_close_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !close);
endmodule

// File: rtl/rxc_combiner.sv
module rxc_combiner
  import rxc_pkg::*;
#(
  parameter int  LEN_W   = 11,
  localparam int BYTES_W = LEN_W + $clog2(MULT_LIMIT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_iso,
  input  logic               cfg_merge,
  input  logic               cfg_hs,
  input  logic [2:0]         cfg_size,
  input  logic [CNT_W-1:0]   cfg_mult,
  input  logic [ISO_W-1:0]   cfg_iso_pkts,
  input  logic               rx_done,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic               uframe_sof,
  input  logic               blk_ack,
  output logic               blk_ready,
  output logic [BYTES_W-1:0] blk_bytes,
  output logic [CNT_W-1:0]   blk_pkts,
  output logic               blk_short
);
  logic               take;
  logic               close;
  logic [BYTES_W-1:0] close_bytes;
  logic [CNT_W-1:0]   close_cnt;
  logic               close_short;
  logic [BYTES_W-1:0] acc_bytes;
  logic [CNT_W-1:0]   acc_cnt;

  rxc_boundary #(.LEN_W(LEN_W), .BYTES_W(BYTES_W)) u_bound (
    .cfg_iso(cfg_iso), .cfg_merge(cfg_merge), .cfg_hs(cfg_hs),
    .cfg_size(cfg_size), .cfg_mult(cfg_mult), .cfg_iso_pkts(cfg_iso_pkts),
    .rx_done(rx_done), .rx_len(rx_len), .uframe_sof(uframe_sof),
    .busy(blk_ready), .acc_bytes(acc_bytes), .acc_cnt(acc_cnt),
    .take(take), .close(close), .close_bytes(close_bytes),
    .close_cnt(close_cnt), .close_short(close_short)
  );

  rxc_accum #(.BYTES_W(BYTES_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .busy(blk_ready), .take(take), .close(close),
    .upd_bytes(close_bytes), .upd_cnt(close_cnt),
    .acc_bytes(acc_bytes), .acc_cnt(acc_cnt)
  );

  rxc_report #(.BYTES_W(BYTES_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .close(close), .close_bytes(close_bytes),
    .close_cnt(close_cnt), .close_short(close_short), .ack(blk_ack),
    .ready(blk_ready), .bytes(blk_bytes), .pkts(blk_pkts), .short_blk(blk_short)
  );

  // R1
  single_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(blk_ready) && !cfg_iso && !cfg_merge) |-> (blk_pkts == CNT_W'(1)));

  // R3
  mult_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(blk_ready) && !cfg_iso && cfg_merge) |-> (blk_pkts <= eff_mult(cfg_mult)));

  // R6
  iso_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_iso |-> (acc_cnt <= CNT_W'(3)));

  // R7
  short_iso_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ready && blk_short) |-> cfg_iso);
endmodule

// File: tb/sim_rxc_combiner.sv
module sim_rxc_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic        iso;
    logic        merge;
    logic        hs;
    logic [2:0]  code;
    logic [5:0]  mult;
    logic [1:0]  ipk;
    logic [2:0]  npk;
    logic [10:0] l0;
    logic [10:0] l1;
    logic [10:0] l2;
    logic [10:0] l3;
    logic        sof;
    logic [15:0] eb;
    logic [5:0]  ep;
    logic        ei;
  } vec_t;

  // iso merge hs code mult ipk npk l0 l1 l2 l3 sof | bytes pkts short
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,3'd3,6'd4, 2'd0,3'd2,11'd64, 11'd64, 11'd0,   11'd0,  1'b0,16'd64,  6'd1, 1'b0}, // R1 R9
    '{1'b0,1'b1,1'b0,3'd3,6'd3, 2'd0,3'd3,11'd64, 11'd64, 11'd64,  11'd0,  1'b0,16'd192, 6'd3, 1'b0}, // R3
    '{1'b0,1'b1,1'b0,3'd3,6'd8, 2'd0,3'd3,11'd64, 11'd64, 11'd20,  11'd0,  1'b0,16'd148, 6'd3, 1'b0}, // R2
    '{1'b0,1'b1,1'b1,3'd4,6'd4, 2'd0,3'd4,11'd512,11'd512,11'd512, 11'd512,1'b0,16'd2048,6'd4, 1'b0}, // R4
    '{1'b0,1'b1,1'b0,3'd4,6'd4, 2'd0,3'd4,11'd100,11'd100,11'd100, 11'd100,1'b0,16'd400, 6'd4, 1'b0}, // R4
    '{1'b0,1'b1,1'b0,3'd0,6'd2, 2'd0,3'd3,11'd8,  11'd8,  11'd8,   11'd0,  1'b0,16'd16,  6'd2, 1'b0}, // R3 R9
    '{1'b0,1'b1,1'b0,3'd1,6'd8, 2'd0,3'd2,11'd16, 11'd0,  11'd0,   11'd0,  1'b0,16'd16,  6'd2, 1'b0}, // R2
    '{1'b1,1'b0,1'b1,3'd0,6'd0, 2'd3,3'd3,11'd1024,11'd1024,11'd1024,11'd0,1'b1,16'd3072,6'd3, 1'b0}, // R5
    '{1'b1,1'b0,1'b1,3'd0,6'd0, 2'd3,3'd2,11'd1024,11'd500,11'd0,  11'd0,  1'b1,16'd1524,6'd2, 1'b1}, // R7
    '{1'b1,1'b0,1'b1,3'd0,6'd0, 2'd1,3'd2,11'd700,11'd700,11'd0,   11'd0,  1'b1,16'd700, 6'd1, 1'b0}, // R6
    '{1'b0,1'b1,1'b0,3'd2,6'd1, 2'd0,3'd2,11'd32, 11'd32, 11'd0,   11'd0,  1'b0,16'd32,  6'd1, 1'b0}, // R3
    '{1'b0,1'b1,1'b0,3'd2,6'd0, 2'd0,3'd1,11'd32, 11'd0,  11'd0,   11'd0,  1'b0,16'd32,  6'd1, 1'b0}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_iso = 1'b0, cfg_merge = 1'b0, cfg_hs = 1'b0;
  logic [2:0]  cfg_size = 3'd0;
  logic [5:0]  cfg_mult = 6'd0;
  logic [1:0]  cfg_iso_pkts = 2'd0;
  logic        rx_done = 1'b0;
  logic [10:0] rx_len = '0;
  logic        uframe_sof = 1'b0;
  logic        blk_ack = 1'b0;
  logic        blk_ready;
  logic [15:0] blk_bytes;
  logic [5:0]  blk_pkts;
  logic        blk_short;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxc_combiner u0 (
    .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cfg_merge(cfg_merge),
    .cfg_hs(cfg_hs), .cfg_size(cfg_size), .cfg_mult(cfg_mult),
    .cfg_iso_pkts(cfg_iso_pkts), .rx_done(rx_done), .rx_len(rx_len),
    .uframe_sof(uframe_sof), .blk_ack(blk_ack), .blk_ready(blk_ready),
    .blk_bytes(blk_bytes), .blk_pkts(blk_pkts), .blk_short(blk_short)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_block(input string req, input int eb, input int ep, input int ei);
    check(blk_ready == 1'b1, req, "ready", int'(blk_ready), 1);
    check(int'(blk_bytes) == eb, req, "bytes", int'(blk_bytes), eb);
    check(int'(blk_pkts) == ep, req, "pkts", int'(blk_pkts), ep);
    check(int'(blk_short) == ei, req, "short", int'(blk_short), ei);
  endtask

  task automatic send_pkt(input int len);
    @(negedge clk);
    rx_done = 1'b1;
    rx_len  = 11'(len);
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  task automatic pulse_sof();
    @(negedge clk);
    uframe_sof = 1'b1;
    @(negedge clk);
    uframe_sof = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    blk_ack = 1'b1;
    @(negedge clk);
    blk_ack = 1'b0;
    check(blk_ready == 1'b0, "R8", "ready after ack", int'(blk_ready), 0);
  endtask

  task automatic set_cfg(input logic iso, input logic merge, input logic hs,
                         input logic [2:0] code, input logic [5:0] mult,
                         input logic [1:0] ipk);
    @(negedge clk);
    cfg_iso = iso; cfg_merge = merge; cfg_hs = hs;
    cfg_size = code; cfg_mult = mult; cfg_iso_pkts = ipk;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(blk_ready == 1'b0, "R10", "ready", int'(blk_ready), 0);
    check(blk_bytes == '0, "R10", "bytes", int'(blk_bytes), 0);
    check(blk_pkts == '0, "R10", "pkts", int'(blk_pkts), 0);
    check(blk_short == 1'b0, "R10", "short", int'(blk_short), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      set_cfg(v.iso, v.merge, v.hs, v.code, v.mult, v.ipk);
      for (int k = 0; k < int'(v.npk); k++) begin
        case (k)
          0: send_pkt(int'(v.l0));
          1: send_pkt(int'(v.l1));
          2: send_pkt(int'(v.l2));
          default: send_pkt(int'(v.l3));
        endcase
      end
      if (v.sof) pulse_sof();
      expect_block($sformatf("vec%0d", i), int'(v.eb), int'(v.ep), int'(v.ei));
      do_ack();
    end

    // R3: 32 packets at the largest multiplier
    set_cfg(1'b0, 1'b1, 1'b0, 3'd0, 6'd32, 2'd0);
    for (int k = 0; k < 31; k++) send_pkt(8);
    check(blk_ready == 1'b0, "R3", "ready after 31 of 32", int'(blk_ready), 0);
    send_pkt(8);
    expect_block("R3", 256, 32, 0);
    do_ack();

    // R5: strobe with nothing gathered makes no block
    set_cfg(1'b1, 1'b0, 1'b1, 3'd0, 6'd0, 2'd2);
    pulse_sof();
    check(blk_ready == 1'b0, "R5", "empty microframe", int'(blk_ready), 0);

    // R5: packet in the same cycle as the strobe joins the closing block
    send_pkt(300);
    @(negedge clk);
    rx_done = 1'b1; rx_len = 11'd200; uframe_sof = 1'b1;
    @(negedge clk);
    rx_done = 1'b0; uframe_sof = 1'b0;
    expect_block("R5", 500, 2, 0);

    // R8: block held across idle cycles without ack
    repeat (5) @(negedge clk);
    expect_block("R8", 500, 2, 0);
    do_ack();

    // R9: packet and strobe while pending are dropped
    set_cfg(1'b1, 1'b0, 1'b1, 3'd0, 6'd0, 2'd3);
    send_pkt(100);
    pulse_sof();
    expect_block("R7", 100, 1, 1);
    send_pkt(50);
    pulse_sof();
    expect_block("R9", 100, 1, 1);
    do_ack();
    pulse_sof();
    check(blk_ready == 1'b0, "R9", "no leak into next block", int'(blk_ready), 0);

    // R8: ack while idle is harmless
    @(negedge clk); blk_ack = 1'b1;
    @(negedge clk); blk_ack = 1'b0;
    check(blk_ready == 1'b0, "R8", "idle ack", int'(blk_ready), 0);

    finish_run();
  end
endmodule